// File: doc/BRIEF.md
# NOR Flash Command Responder

This block is the device side of a serial NOR flash, cut at the byte level. A shifter in front of it (not part of this block) delivers each received byte together with a one-cycle strobe, and it holds a chip-select level. The block decodes the opcode, gathers the address, and gives the byte that the shifter sends on the next transfer. It answers two identification sequences, keeps a status register, and enforces the write-enable latch, block protection and busy rules on every command that changes the array.

Data movement goes through a simple request port. Each request is a single-cycle pulse carrying an operation code, a 24-bit byte address and, for writes, a data byte. Read data are expected on the cycle after the request, as from a block RAM. A programmable busy counter stands in for the array's program and erase time.

Top module: `nor_cmd_responder`

## Requirements
- R1: After reset the reply byte is 0xFF, no memory request is issued, and the status byte reads 0x00.
- R2: Opcode 0x9F replies, on the following transfers, with the maker ID, the memory-type byte 0x20 and the device ID, then 0xFF.
- R3: Opcode 0x90 is followed by two ignored bytes and a selector byte; if selector bit 0 is 0 the next two replies are maker ID then device ID, if it is 1 the order is device ID then maker ID; later replies are 0xFF.
- R4: Opcode 0x05 replies with the current status byte on every further transfer until select is released; status bit 0 is busy, bit 1 is the write-enable latch, bits 5:2 are block protect, bit 6 reads 0, bit 7 locks the status register.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R6: Page program (0x02), sector erase (0x20) and status write (0x01) are ignored unless the latch is set; program and erase are also ignored while any block-protect bit is set; status write is also ignored while bit 7 is set. An ignored command leaves the latch unchanged and issues no memory request.
- R7: An accepted program (at least one data byte), erase (all three address bytes) or status write (the data byte) completes when select is released: the latch clears, a status write takes its bits 7 and 5:2 from the data byte, and the busy bit is set for exactly BUSY_CYCLES clock cycles.
- R8: While busy, only opcode 0x05 is honoured; any other command replies 0xFF, issues no request and changes no state.
- R9: Read (0x03) takes a 24-bit address, most significant byte first; a read request (op 0) for the address is issued on the last address byte and one for the next address on each further byte, the address wrapping from 0xFFFFFF to 0; each fetched byte is the reply of the next transfer.
- R10: Each page-program data byte issues one write request (op 1) with that byte; the address advances in its low 8 bits only, wrapping within its 256-byte page.
- R11: An accepted sector erase issues one erase request (op 2) on the last address byte, with address bits 11:0 cleared.
- R12: While select is inactive the reply byte is 0xFF and strobes have no effect; every memory request follows a strobe taken while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_active | input | 1 | Chip select, 1 while the device is selected |
| byte_stb | input | 1 | One-cycle pulse: mosi_byte holds a received byte |
| mosi_byte | input | 8 | Byte received from the host |
| miso_byte | output | 8 | Byte to send on the next transfer |
| mem_req | output | 1 | One-cycle memory request |
| mem_op | output | 2 | 0 read, 1 write, 2 erase |
| mem_addr | output | 24 | Byte address of the request |
| mem_wdata | output | 8 | Data byte of a write request |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
A wrong latch, protection or busy state shows up as a memory request that should not exist, or a missing one, in the very cycle after the strobe that carried the last address or data byte, and the status byte read back one transfer later exposes it directly. A wrong address register shows as a request address off by the page wrap or the array wrap on the first byte that crosses a boundary. A wrong byte index shows as an identification byte out of order one transfer after the opcode or selector. The busy window is measured to the cycle, so an off-by-one counter is caught when busy drops.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_IDSEL = 8'h90;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    MEM_RD = 2'd0,
    MEM_WR = 2'd1,
    MEM_ER = 2'd2
  } mem_op_e;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int BUSY_CYCLES = 100,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (start) cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nor_addr_step.sv
module nor_addr_step #(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              page_mode,
  output logic [ADDR_W-1:0] addr_out
);
  logic [PAGE_W-1:0] low_inc;
  assign low_inc = addr_in[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    if (page_mode) addr_out = {addr_in[ADDR_W-1:PAGE_W], low_inc};
    else           addr_out = addr_in + ADDR_W'(1);
  end
endmodule

// File: rtl/nor_cmd_responder.sv
module nor_cmd_responder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int SECTOR_W = 12,
  parameter int BUSY_CYCLES = 100,
  parameter logic [7:0] MAKER_ID = 8'hC2,
  parameter logic [7:0] MEM_TYPE = 8'h20,
  parameter logic [7:0] DEVICE_ID = 8'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_active,
  input  logic              byte_stb,
  input  logic [7:0]        mosi_byte,
  output logic [7:0]        miso_byte,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int DATA_IDX = ADDR_BYTES + 1;
  localparam int IDX_MAX = DATA_IDX + 1;
  localparam int IDX_W = $clog2(IDX_MAX + 1);
  localparam int SEL_IDX = 3;

  logic              in_txn, skip_q, done_q, sel_dev_q, rd_load;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        cmd_q, new_sr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wel_q, srwd_q, wip;
  logic [3:0]        bp_q;
  logic [7:0]        status;
  logic              allowed, commit, last_addr, data_phase;
  logic [ADDR_W-1:0] addr_full, step_in, step_out;

  assign status     = {srwd_q, 1'b0, bp_q, wel_q, wip};
  assign addr_full  = {addr_q[ADDR_W-9:0], mosi_byte};
  assign last_addr  = (idx == IDX_W'(ADDR_BYTES));
  assign data_phase = (idx >= IDX_W'(DATA_IDX));
  assign step_in    = last_addr ? addr_full : addr_q;
  assign commit     = !cs_active && in_txn && done_q && !skip_q;

  nor_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .addr_in  (step_in),
    .page_mode(cmd_q == OP_PROG),
    .addr_out (step_out)
  );

  nor_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk  (clk),
    .rst  (rst),
    .start(commit),
    .busy (wip)
  );

  // Decide whether the opcode now on mosi_byte may run.
  always_comb begin
    if (wip) allowed = (mosi_byte == OP_RDSR);
    else begin
      case (mosi_byte)
        OP_PROG, OP_ERASE: allowed = wel_q && (bp_q == 4'd0);
        OP_WRSR:           allowed = wel_q && !srwd_q;
        OP_RDID, OP_IDSEL, OP_READ, OP_RDSR,
        OP_WREN, OP_WRDI:  allowed = 1'b1;
        default:           allowed = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_txn    <= 1'b0;
      idx       <= '0;
      cmd_q     <= '0;
      skip_q    <= 1'b0;
      done_q    <= 1'b0;
      sel_dev_q <= 1'b0;
      new_sr_q  <= '0;
      addr_q    <= '0;
      wel_q     <= 1'b0;
      srwd_q    <= 1'b0;
      bp_q      <= '0;
      rd_load   <= 1'b0;
      miso_byte <= IDLE_BYTE;
      mem_req   <= 1'b0;
      mem_op    <= MEM_RD;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      rd_load <= mem_req && (mem_op == MEM_RD);
      if (rd_load && cs_active) miso_byte <= mem_rdata;

      if (!cs_active) begin
        miso_byte <= IDLE_BYTE;
        in_txn    <= 1'b0;
        idx       <= '0;
        done_q    <= 1'b0;
        if (commit) begin
          wel_q <= 1'b0;
          if (cmd_q == OP_WRSR) begin
            srwd_q <= new_sr_q[7];
            bp_q   <= new_sr_q[5:2];
          end
        end
      end else if (byte_stb) begin
        in_txn <= 1'b1;
        if (idx != IDX_W'(IDX_MAX)) idx <= idx + 1'b1;
        if (idx == '0) begin
          cmd_q  <= mosi_byte;
          skip_q <= !allowed;
          miso_byte <= IDLE_BYTE;
          if (allowed) begin
            if (mosi_byte == OP_RDID) miso_byte <= MAKER_ID;
            if (mosi_byte == OP_RDSR) miso_byte <= status;
            if (mosi_byte == OP_WREN) wel_q <= 1'b1;
            if (mosi_byte == OP_WRDI) wel_q <= 1'b0;
          end
        end else if (skip_q) begin
          miso_byte <= IDLE_BYTE;
        end else begin
          miso_byte <= IDLE_BYTE;
          case (cmd_q)
            OP_RDSR: miso_byte <= status;
            OP_RDID: begin
              if (idx == IDX_W'(1)) miso_byte <= MEM_TYPE;
              if (idx == IDX_W'(2)) miso_byte <= DEVICE_ID;
            end
            OP_IDSEL: begin
              if (idx == IDX_W'(SEL_IDX)) begin
                sel_dev_q <= mosi_byte[0];
                miso_byte <= mosi_byte[0] ? DEVICE_ID : MAKER_ID;
              end
              if (idx == IDX_W'(SEL_IDX + 1))
                miso_byte <= sel_dev_q ? MAKER_ID : DEVICE_ID;
            end
            OP_WRSR: begin
              if (idx == IDX_W'(1)) begin
                new_sr_q <= mosi_byte;
                done_q   <= 1'b1;
              end
            end
            OP_READ, OP_PROG, OP_ERASE: begin
              if (!last_addr && !data_phase) begin
                addr_q <= addr_full;
              end else if (last_addr) begin
                addr_q <= (cmd_q == OP_READ) ? step_out : addr_full;
                if (cmd_q == OP_READ) begin
                  mem_req  <= 1'b1;
                  mem_op   <= MEM_RD;
                  mem_addr <= addr_full;
                end
                if (cmd_q == OP_ERASE) begin
                  mem_req  <= 1'b1;
                  mem_op   <= MEM_ER;
                  mem_addr <= {addr_full[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
                  done_q   <= 1'b1;
                end
              end else if (cmd_q != OP_ERASE) begin
                addr_q   <= step_out;
                mem_req  <= 1'b1;
                mem_addr <= addr_q;
                if (cmd_q == OP_PROG) begin
                  mem_op    <= MEM_WR;
                  mem_wdata <= mosi_byte;
                  done_q    <= 1'b1;
                end else begin
                  mem_op <= MEM_RD;
                end
              end
            end
            default: miso_byte <= IDLE_BYTE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_responder_chk.sv
module nor_cmd_responder_chk #(
  parameter int ADDR_W = 24,
  parameter int SECTOR_W = 12,
  parameter int BUSY_CYCLES = 100,
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_active,
  input logic              byte_stb,
  input logic [7:0]        miso_byte,
  input logic              mem_req,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wel_q,
  input logic              wip
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (wip) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_ERASE_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'd2) |-> (mem_addr[SECTOR_W-1:0] == '0)); // R11
  AST_MODIFY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op != 2'd0) |-> wel_q); // R6
  AST_NO_REQUEST_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !wip); // R8
  AST_BUSY_EXACT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> (run_q == RUN_W'(BUSY_CYCLES))); // R7
  AST_IDLE_REPLY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> (miso_byte == 8'hFF)); // R12
  AST_REQUEST_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(byte_stb && cs_active)); // R12
endmodule

bind nor_cmd_responder nor_cmd_responder_chk #(
  .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_active(cs_active), .byte_stb(byte_stb),
  .miso_byte(miso_byte), .mem_req(mem_req), .mem_op(mem_op),
  .mem_addr(mem_addr), .wel_q(wel_q), .wip(wip)
);

// File: tb/nor_cmd_responder_test.sv
module nor_cmd_responder_test;
  localparam int BUSY = 100;
  localparam int MAKER = 8'hC2;
  localparam int DEV = 8'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_active = 1'b0;
  logic byte_stb = 1'b0;
  logic [7:0] mosi_byte = 8'h00;
  logic [7:0] miso_byte;
  logic mem_req;
  logic [1:0] mem_op;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'hFF;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Behavioural model state
  int exp_op[$];
  int exp_addr[$];
  int exp_data[$];
  logic [7:0] ref_mem[int];
  logic [7:0] dev_mem[int];
  bit m_wel = 0, m_wip = 0, m_srwd = 0;
  int m_bp = 0;
  logic cs_prev = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_responder #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .cs_active(cs_active), .byte_stb(byte_stb),
    .mosi_byte(mosi_byte), .miso_byte(miso_byte), .mem_req(mem_req),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Array behind the request port, one cycle read latency
  always @(posedge clk) begin
    cs_prev <= cs_active;
    if (!rst && mem_req) begin
      if (mem_op == 2'd0)
        mem_rdata <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'hFF;
      else if (mem_op == 2'd1)
        dev_mem[int'(mem_addr)] = mem_wdata;
      else if (mem_op == 2'd2)
        for (int i = 0; i < 4096; i++) dev_mem.delete(int'(mem_addr) + i);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every clock: requests against the model queue, idle reply when deselected
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (mem_req) begin
        if (exp_op.size() == 0) check(0, "R6/R8", "unexpected request op", int'(mem_op), -1);
        else begin
          int o, a, d;
          o = exp_op.pop_front(); a = exp_addr.pop_front(); d = exp_data.pop_front();
          check(int'(mem_op) == o, "R9/R10/R11", "request op", int'(mem_op), o);
          check(int'(mem_addr) == a, "R9/R10/R11", "request addr", int'(mem_addr), a);
          if (o == 1) check(int'(mem_wdata) == d, "R10", "write data", int'(mem_wdata), d);
        end
      end
      if (!cs_prev) check(miso_byte == 8'hFF, "R12", "deselected reply", int'(miso_byte), 8'hFF);
    end
  end

  function automatic void want(input int op, input int addr, input int data);
    exp_op.push_back(op); exp_addr.push_back(addr & 24'hFFFFFF); exp_data.push_back(data);
  endfunction

  function automatic int ref_rd(input int a);
    return ref_mem.exists(a & 24'hFFFFFF) ? int'(ref_mem[a & 24'hFFFFFF]) : 8'hFF;
  endfunction

  function automatic int m_status();
    return (int'(m_srwd) << 7) | (m_bp << 2) | (int'(m_wel) << 1) | int'(m_wip);
  endfunction

  task automatic run_txn(input logic [7:0] tx[$], input int rx[$], input string req);
    @(negedge clk); cs_active = 1'b1; @(negedge clk);
    foreach (tx[i]) begin
      if (rx[i] >= 0) check(int'(miso_byte) == rx[i], req, "reply byte", int'(miso_byte), rx[i]);
      byte_stb = 1'b1; mosi_byte = tx[i];
      @(negedge clk); byte_stb = 1'b0;
      repeat (3) @(negedge clk);
    end
    cs_active = 1'b0;
    repeat (2) @(negedge clk);
    check(exp_op.size() == 0, req, "requests still owed", exp_op.size(), 0);
  endtask

  task automatic read_status(input string req);
    int s;
    s = m_status();
    run_txn('{8'h05, 8'h00, 8'h00, 8'h00}, '{8'hFF, s, s, s}, req);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 10) @(negedge clk);
    m_wip = 0;
  endtask

  task automatic one_byte(input logic [7:0] op, input string req);
    run_txn('{op}, '{8'hFF}, req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miso_byte == 8'hFF, "R1", "reset reply", int'(miso_byte), 8'hFF);
    check(mem_req == 1'b0, "R1", "reset request", int'(mem_req), 0);
    read_status("R1 reset status");

    run_txn('{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00}, '{8'hFF, MAKER, 8'h20, DEV, 8'hFF}, "R2");
    run_txn('{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
            '{8'hFF, 8'hFF, 8'hFF, 8'hFF, MAKER, DEV, 8'hFF}, "R3 sel0");
    run_txn('{8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00},
            '{8'hFF, 8'hFF, 8'hFF, 8'hFF, DEV, MAKER, 8'hFF}, "R3 sel1");

    // R6: program without the latch
    run_txn('{8'h02, 8'h00, 8'h10, 8'h00, 8'hAA}, '{-1, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R6 no latch");
    read_status("R6 status after ignored program");

    one_byte(8'h06, "R5 set"); m_wel = 1;
    read_status("R5 latch set");
    one_byte(8'h04, "R5 clear"); m_wel = 0;
    read_status("R5 latch clear");

    // R10: page program wrapping inside the page
    one_byte(8'h06, "R5"); m_wel = 1;
    want(1, 24'h0012FE, 8'h11); want(1, 24'h0012FF, 8'h22);
    want(1, 24'h001200, 8'h33); want(1, 24'h001201, 8'h44);
    ref_mem[24'h0012FE] = 8'h11; ref_mem[24'h0012FF] = 8'h22;
    ref_mem[24'h001200] = 8'h33; ref_mem[24'h001201] = 8'h44;
    run_txn('{8'h02, 8'h00, 8'h12, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44},
            '{-1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R10");
    m_wel = 0; m_wip = 1;
    read_status("R7 busy after program");
    one_byte(8'h06, "R8 latch while busy");
    run_txn('{8'h03, 8'h00, 8'h12, 8'hFE, 8'h00}, '{-1, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R8 read while busy");
    read_status("R8 status after ignored commands");
    wait_idle();
    read_status("R7 busy ended");

    // R9: read increments across the page boundary
    want(0, 24'h0012FE, 0); want(0, 24'h0012FF, 0); want(0, 24'h001300, 0);
    want(0, 24'h001301, 0); want(0, 24'h001302, 0);
    run_txn('{8'h03, 8'h00, 8'h12, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00},
            '{-1, 8'hFF, 8'hFF, 8'hFF, ref_rd(24'h0012FE), ref_rd(24'h0012FF),
              ref_rd(24'h001300), ref_rd(24'h001301)}, "R9 cross page");
    want(0, 24'h001200, 0); want(0, 24'h001201, 0); want(0, 24'h001202, 0);
    run_txn('{8'h03, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00},
            '{-1, 8'hFF, 8'hFF, 8'hFF, ref_rd(24'h001200), ref_rd(24'h001201)}, "R10 wrapped bytes");
    want(0, 24'hFFFFFE, 0); want(0, 24'hFFFFFF, 0); want(0, 24'h000000, 0);
    run_txn('{8'h03, 8'hFF, 8'hFF, 8'hFE, 8'h00, 8'h00},
            '{-1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R9 array wrap");

    // R11: sector erase
    one_byte(8'h06, "R5"); m_wel = 1;
    want(2, 24'h001000, 0);
    for (int i = 0; i < 4096; i++) ref_mem.delete(24'h001000 + i);
    run_txn('{8'h20, 8'h00, 8'h12, 8'h34}, '{-1, 8'hFF, 8'hFF, 8'hFF}, "R11");
    m_wel = 0; m_wip = 1;
    read_status("R7 busy after erase");
    wait_idle();
    want(0, 24'h001200, 0); want(0, 24'h001201, 0);
    run_txn('{8'h03, 8'h00, 8'h12, 8'h00, 8'h00},
            '{-1, 8'hFF, 8'hFF, 8'hFF, ref_rd(24'h001200)}, "R11 erased data");

    // R4/R7: status write sets protection
    one_byte(8'h06, "R5"); m_wel = 1;
    run_txn('{8'h01, 8'h3C}, '{-1, 8'hFF}, "R7 status write");
    m_wel = 0; m_wip = 1; m_bp = 4'hF;
    read_status("R4 busy after status write");
    wait_idle();
    read_status("R4 protect bits");

    // R6: protection blocks program and erase, latch kept
    one_byte(8'h06, "R5"); m_wel = 1;
    run_txn('{8'h02, 8'h00, 8'h00, 8'h10, 8'h55}, '{-1, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R6 protected program");
    run_txn('{8'h20, 8'h00, 8'h20, 8'h00}, '{-1, 8'hFF, 8'hFF, 8'hFF}, "R6 protected erase");
    read_status("R6 latch kept");

    run_txn('{8'h01, 8'h80}, '{-1, 8'hFF}, "R7 status lock");
    m_wel = 0; m_wip = 1; m_bp = 0; m_srwd = 1;
    wait_idle();
    read_status("R4 lock bit");
    one_byte(8'h06, "R5"); m_wel = 1;
    run_txn('{8'h01, 8'h00}, '{-1, 8'hFF}, "R6 locked status write");
    read_status("R6 status unchanged while locked");
    one_byte(8'h04, "R5"); m_wel = 0;

    // Unknown opcode and strobes while deselected
    run_txn('{8'hAB, 8'h00, 8'h00}, '{-1, 8'hFF, 8'hFF}, "R12 unknown opcode");
    @(negedge clk); byte_stb = 1'b1; mosi_byte = 8'h06;
    @(negedge clk); byte_stb = 1'b0;
    repeat (2) @(negedge clk);
    check(miso_byte == 8'hFF, "R12", "reply after stray strobe", int'(miso_byte), 8'hFF);
    read_status("R12 stray strobe ignored");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule